// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block maps a 32-bit system address onto one of eight programmable chip-select windows. Each window is described by a small configuration word. The word holds an enable flag, a 6-bit base that selects a 16 MB-aligned starting address, and a 4-bit size mask. The decoder compares the upper address byte against every enabled window in parallel. It returns a one-hot chip-select vector with the lowest-numbered matching window winning, and it returns the byte offset of the address inside that window.

Software programs a window by writing its configuration word through a single-cycle write port. The new setting governs decoding from the clock edge that captures the write. When a write enables a window with a size mask outside the legal set, the block raises a one-cycle error pulse. The mask value that selects a 256 MB window is legal only when the `ALLOW_FULL_SPAN` parameter is set.

The block has no state machine: its only state is the eight configuration registers and the error pulse flop. Write, reset and the two combinational paths (match and offset) are its whole behaviour.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, window 0 is enabled with base 0 and mask 0xF, so it covers 0x00000000 to 0x00FFFFFF. Windows 1 to 7 are disabled with mask 0xF and base 0. `mask_err` is 0.
- R2: The configuration word uses these fields: base in bits 5:0, enable in bit 6, and mask in bits 11:8. Bit 7 and bits 31:12 of `cfg_wr_data` have no effect on decoding or on `mask_err`.
- R3: A window's base address is its base field shifted left by 24. An enabled window matches when (addr[31:24] & {4'hF,mask}) equals ({2'b00,base} & {4'hF,mask}).
- R4: Window size is (0x0FFFFFFF & ~(mask<<24)) + 1. Mask 0x8 gives 128 MB, 0xC gives 64 MB, 0xE gives 32 MB and 0xF gives 16 MB.
- R5: A window whose enable bit is 0 never matches.
- R6: When several windows match, only the lowest-numbered one appears on `cs_hit`.
- R7: `cs_hit` has at most one bit set. `cs_any` is 1 exactly when a bit of `cs_hit` is set.
- R8: `addr_offset` equals addr[27:0] & (size-1) of the winning window. It is 0 when no window matches.
- R9: `mask_err` is 1 for exactly the one cycle after the clock edge that captures a write with the enable bit set and a mask other than 0x8, 0xC, 0xE or 0xF. Mask 0x0 is also accepted when `ALLOW_FULL_SPAN` is 1. With the default of 0, mask 0x0 is flagged.
- R10: A write captured at a clock edge changes decoding immediately after that edge, and only for the window named by `cfg_wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 3 | Window number to write |
| cfg_wr_data | input | 32 | Configuration word |
| addr | input | 32 | System address to decode |
| cs_hit | output | 8 | One-hot chip-select match |
| cs_any | output | 1 | Some window matched |
| addr_offset | output | 28 | Offset inside the winning window |
| mask_err | output | 1 | Illegal-mask write pulse |

## Verification
A wrong configuration register shows at the ports as soon as an address reaches the edge of that window. The error appears on the cycle after the faulty write, either as a missed or extra hit or as an offset carrying too many or too few bits. A broken priority chain shows only where windows overlap, so overlapping windows are set up on purpose. A stuck or stretched error flop appears on the cycle after a write, or on the cycle after that.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int BASE_W = 6;
    localparam int MASK_W = 4;
    localparam int GRAN_W = 24;
    localparam int HI_W   = BASE_W + 2;
    localparam int OFS_W  = GRAN_W + MASK_W;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              valid;
        logic [BASE_W-1:0] base;
    } cs_cfg_t;

    localparam cs_cfg_t CFG_RESET = '{mask: 4'hF, valid: 1'b0, base: '0};

    function automatic cs_cfg_t word_to_cfg(input logic [11:0] w);
        cs_cfg_t c;
        c.mask  = w[11:8];
        c.valid = w[6];
        c.base  = w[5:0];
        return c;
    endfunction

    function automatic logic mask_legal(input logic [MASK_W-1:0] m, input logic full_ok);
        logic ok;
        unique case (m)
            4'h8, 4'hC, 4'hE, 4'hF: ok = 1'b1;
            4'h0:                   ok = full_ok;
            default:                ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cs_win_reg.sv
module cs_win_reg
    import cs_dec_pkg::*;
#(
    parameter bit START_VALID = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [11:0] wr_word,
    output cs_cfg_t    cfg
);
    cs_cfg_t cfg_q;
    cs_cfg_t rst_val;

    always_comb begin
        rst_val       = CFG_RESET;
        rst_val.valid = START_VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= rst_val;
        end else if (wr_en) begin
            cfg_q <= word_to_cfg(wr_word);
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/cs_win_match.sv
module cs_win_match
    import cs_dec_pkg::*;
(
    input  logic [HI_W-1:0] addr_hi,
    input  cs_cfg_t         cfg,
    output logic            hit
);
    logic [HI_W-1:0] cmp_mask;
    logic [HI_W-1:0] base_ext;

    always_comb begin
        cmp_mask = {{(HI_W-MASK_W){1'b1}}, cfg.mask};
        base_ext = {{(HI_W-BASE_W){1'b0}}, cfg.base};
        hit      = cfg.valid && ((addr_hi & cmp_mask) == (base_ext & cmp_mask));
    end
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel
    import cs_dec_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic [NUM_CS-1:0]          raw_hit,
    input  cs_cfg_t [NUM_CS-1:0]       cfgs,
    input  logic [OFS_W-1:0]           addr_lo,
    output logic [NUM_CS-1:0]          win_hit,
    output logic                       any_hit,
    output logic [OFS_W-1:0]           offset
);
    logic [MASK_W-1:0] win_mask;

    always_comb begin
        win_hit  = '0;
        any_hit  = 1'b0;
        win_mask = '1;
        for (int i = 0; i < NUM_CS; i++) begin
            if (raw_hit[i] && !any_hit) begin
                win_hit[i] = 1'b1;
                any_hit    = 1'b1;
                win_mask   = cfgs[i].mask;
            end
        end
        offset = any_hit ? (addr_lo & {~win_mask, {GRAN_W{1'b1}}}) : '0;
    end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import cs_dec_pkg::*;
#(
    parameter int NUM_CS          = 8,
    parameter bit ALLOW_FULL_SPAN = 1'b0,
    localparam int SEL_W          = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    input  logic [31:0]       addr,
    output logic [NUM_CS-1:0] cs_hit,
    output logic              cs_any,
    output logic [OFS_W-1:0]  addr_offset,
    output logic              mask_err
);
    cs_cfg_t [NUM_CS-1:0] cfgs;
    logic [NUM_CS-1:0]    raw_hit;
    logic                 unused_wr_bits;
    cs_cfg_t              wr_cfg;
    logic                 err_d;

    assign unused_wr_bits = ^{cfg_wr_data[31:12], cfg_wr_data[7]};

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        cs_win_reg #(.START_VALID(g == 0)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr_en && (cfg_wr_sel == SEL_W'(g))),
            .wr_word (cfg_wr_data[11:0]),
            .cfg     (cfgs[g])
        );
        cs_win_match u_match (
            .addr_hi (addr[31 -: HI_W]),
            .cfg     (cfgs[g]),
            .hit     (raw_hit[g])
        );
    end

    cs_prio_sel #(.NUM_CS(NUM_CS)) u_sel (
        .raw_hit (raw_hit),
        .cfgs    (cfgs),
        .addr_lo (addr[OFS_W-1:0]),
        .win_hit (cs_hit),
        .any_hit (cs_any),
        .offset  (addr_offset)
    );

    always_comb begin
        wr_cfg = word_to_cfg(cfg_wr_data[11:0]);
        err_d  = cfg_wr_en && wr_cfg.valid && !mask_legal(wr_cfg.mask, ALLOW_FULL_SPAN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_err <= 1'b0;
        end else begin
            mask_err <= err_d;
        end
    end
endmodule

// File: rtl/cs_window_decoder_chk.sv
module cs_window_decoder_chk #(
    parameter int NUM_CS = 8,
    parameter int SEL_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [SEL_W-1:0]  cfg_wr_sel,
    input logic [31:0]       cfg_wr_data,
    input logic [31:0]       addr,
    input logic [NUM_CS-1:0] cs_hit,
    input logic              cs_any,
    input logic [27:0]       addr_offset,
    input logic              mask_err
);
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_hit)); // R7

    AST_ANY_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        cs_any == ($countones(cs_hit) == 1)); // R7

    AST_MISS_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_any |-> (addr_offset == '0)); // R8

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |-> ($past(cfg_wr_en) && $past(cfg_wr_data[6]))); // R9

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_wr_en) && $stable(addr)) |-> $stable(cs_hit)); // R10

    AST_HIGH_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[31:30] != 2'b00) |-> !cs_any); // R3
endmodule

bind cs_window_decoder cs_window_decoder_chk #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .addr        (addr),
    .cs_hit      (cs_hit),
    .cs_any      (cs_any),
    .addr_offset (addr_offset),
    .mask_err    (mask_err)
);

// File: tb/sim_cs_window_decoder.sv
module sim_cs_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] addr = '0;
    logic [7:0]  cs_hit;
    logic        cs_any;
    logic [27:0] addr_offset;
    logic        mask_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [11:0] model [8];

    always #2 clk = ~clk;

    cs_window_decoder u0 (
        .clk (clk), .rst_n (rst_n), .cfg_wr_en (cfg_wr_en), .cfg_wr_sel (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data), .addr (addr), .cs_hit (cs_hit), .cs_any (cs_any),
        .addr_offset (addr_offset), .mask_err (mask_err)
    );

    function automatic logic [31:0] span_m1(input logic [3:0] m);
        return 32'h0FFF_FFFF & ~({m, 24'h0} & 32'h0F00_0000);
    endfunction

    function automatic logic win_covers(input logic [11:0] w, input logic [31:0] a);
        logic [31:0] keep;
        keep = ~span_m1(w[11:8]);
        return w[6] && ((a & keep) == ({26'h0, w[5:0]} << 24 & keep));
    endfunction

    function automatic logic [7:0] exp_hit(input logic [31:0] a);
        for (int i = 0; i < 8; i++)
            if (win_covers(model[i], a)) return 8'h1 << i;
        return 8'h0;
    endfunction

    function automatic logic [27:0] exp_ofs(input logic [31:0] a);
        for (int i = 0; i < 8; i++)
            if (win_covers(model[i], a)) return 28'(a & span_m1(model[i][11:8]));
        return 28'h0;
    endfunction

    function automatic logic exp_err(input logic [31:0] d);
        logic [3:0] m;
        m = d[11:8];
        return d[6] && !(m == 4'h8 || m == 4'hC || m == 4'hE || m == 4'hF);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic [31:0] a);
        @(negedge clk);
        addr = a;
        #1;
        check(req, {24'h0, cs_hit}, {24'h0, exp_hit(a)});
        check(req, {31'h0, cs_any}, {31'h0, exp_hit(a) != 8'h0});
        check(req, {4'h0, addr_offset}, {4'h0, exp_ofs(a)});
    endtask

    task automatic wr(input string req, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wr_data = $urandom;
        model[sel] = d[11:0] & 12'hF7F;
        check(req, {31'h0, mask_err}, {31'h0, exp_err(d)});
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) model[i] = 12'hF00;
        model[0] = 12'hF40;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", {31'h0, mask_err}, 32'h0);
        probe("R1", 32'h0012_3456);
        check("R1", {24'h0, cs_hit}, 32'h1);
        probe("R1", 32'h0100_0000);
        check("R1", {31'h0, cs_any}, 32'h0);
        // R2 junk in bit 7 and high bits, R3/R4 128 MB at 0x10000000
        wr("R2", 3'd3, 32'hABCD_08D0);
        probe("R4", 32'h17FF_FFFF);
        check("R4", {24'h0, cs_hit}, 32'h8);
        check("R4", {4'h0, addr_offset}, 32'h07FF_FFFF);
        probe("R4", 32'h1800_0000);
        probe("R3", 32'hC000_0000);
        // R6 overlap: window 1 32 MB at 0
        wr("R10", 3'd1, 32'h0000_0E40);
        probe("R6", 32'h0080_0000);
        check("R6", {24'h0, cs_hit}, 32'h1);
        probe("R6", 32'h0180_0000);
        check("R8", {4'h0, addr_offset}, 32'h0180_0000);
        // R5 disabled window
        wr("R5", 3'd1, 32'h0000_0E00);
        probe("R5", 32'h0180_0000);
        check("R5", {31'h0, cs_any}, 32'h0);
        // R9 illegal masks
        wr("R9", 3'd5, 32'h0000_0540);
        @(negedge clk);
        check("R9", {31'h0, mask_err}, 32'h0);
        wr("R9", 3'd5, 32'h0000_0500);
        wr("R9", 3'd6, 32'h0000_0041);
        probe("R4", 32'h0100_0000);
        wr("R9", 3'd6, 32'h0000_0F00);
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [3:0] m;
            logic [31:0] d;
            case ($urandom_range(0, 4))
                0: m = 4'h8;
                1: m = 4'hC;
                2: m = 4'hE;
                3: m = 4'hF;
                default: m = 4'($urandom);
            endcase
            d = ($urandom & 32'hFFFF_F0BF) | {20'h0, m, 8'h0};
            if ($urandom_range(0, 3) != 0) d[6] = 1'b1;
            wr("R9", 3'($urandom), d);
            for (int j = 0; j < 4; j++) begin
                logic [31:0] a;
                a = $urandom;
                if ($urandom_range(0, 7) != 0) a[31:30] = 2'b00;
                if ($urandom_range(0, 1) != 0) a[29:28] = 2'b00;
                probe("R8", a);
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule